// File: doc/BRIEF.md
# Two-Command Burst Access Sequencer

This block sits on the controller side of a memory that takes each column access as two commands. The first command starts a read or a write. The second command latches the lower column address. The block holds a small mode word that sets the burst length (2 or 4 beats), the burst order (sequential or interleaved) and the CAS latency (4, 5 or 6). At the latch command it copies the mode settings and the column address, and then it counts clock cycles from that command. For a read it raises a capture enable CL cycles later. For a write it raises a drive enable one cycle earlier than that.

While either enable is high, the block presents the column address of the current beat. The address follows the selected order: in sequential order it wraps inside the low address bits, and in interleaved order it is the start address XOR the beat index. A one-cycle done flag marks the last beat. A mode load with an illegal field is refused and raises an error flag. A latch command that has no access command before it is ignored, and so is an access command that arrives while an earlier access is still pending.

Top module: `burst_seq_top`

## Requirements
- R1: After synchronous reset the capture enable, drive enable, done flag and error flag are low, and the mode is burst length 4, sequential order, CL 4.
- R2: A mode load takes its fields from the load word as follows. Bits [2:0] hold the burst code, where 1 selects 2 beats and 2 selects 4 beats. Bit [3] selects the order, where 0 is sequential and 1 is interleaved. Bits [6:4] hold the CL code, where 3'b100, 3'b101 and 3'b110 select 4, 5 and 6. Bit [7] and bits [14:8] must be 0. A legal load sets the mode used by later accesses and clears the error flag.
- R3: A load with a reserved burst code, a reserved CL code, or a nonzero bit 7 or bit in [14:8] sets the error flag and leaves the mode unchanged.
- R4: For a read, the capture enable first goes high in the cycle that opens at the CL-th rising edge after the edge that sampled the latch command.
- R5: For a write, the drive enable first goes high one cycle earlier than a read would, at edge CL-1 after the latch edge.
- R6: Each enable stays high for exactly burst-length consecutive cycles. The done flag is high only in the last of those cycles.
- R7: In sequential order, beat b presents the start address with its low bits replaced by (start + b). The sum is taken modulo 2 on bit 0 for 2 beats and modulo 4 on bits [1:0] for 4 beats, with no carry into higher bits.
- R8: In interleaved order, beat b presents the start address with its low bits (bit 0 for 2 beats, bits [1:0] for 4 beats) XORed with b.
- R9: The column bits above the wrapped low bits equal those of the latched start address for every beat.
- R10: A latch command that arrives when no access command is pending has no effect: no enable rises.
- R11: An access command or latch command that arrives while an access is waiting or bursting is refused. A later lone latch command then starts nothing.
- R12: The mode settings for an access are those in effect before the latch edge. A mode load sampled at the same edge as the latch command applies only to later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_load | input | 1 | Mode word load strobe |
| mr_data | input | MR_W | Mode word |
| cmd_rd | input | 1 | Read access-start command (takes priority over cmd_wr) |
| cmd_wr | input | 1 | Write access-start command |
| cmd_lal | input | 1 | Lower-address latch command |
| col_in | input | COL_W | Column address latched with cmd_lal |
| beat_col | output | COL_W | Column address of the current beat while an enable is high |
| rd_cap_en | output | 1 | Read data capture enable |
| wr_drv_en | output | 1 | Write data drive enable |
| burst_done | output | 1 | High on the last beat of a burst |
| mr_err | output | 1 | The last mode load was refused |

## Verification
A mode load and a latch command can be sampled at the same edge. The bench provokes this by raising the load strobe with a new CL and burst length in the cycle it raises the latch command. It then checks that this burst keeps the old timing and length, and that the next access uses the new settings. A second collision is an access or latch command that lands inside a running burst. The bench injects both during a read, checks that the read proceeds unchanged, and then sends a lone latch command that must start nothing.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ARMED,
    PH_WAIT,
    PH_BURST
  } phase_e;

  typedef struct packed {
    logic       four;  // 1: four beats, 0: two beats
    logic       ilv;   // 1: interleaved order
    logic [2:0] cl;    // latency in cycles, code equals value
  } mode_t;

  localparam logic [2:0] BLC_TWO  = 3'd1;
  localparam logic [2:0] BLC_FOUR = 3'd2;
  localparam logic [2:0] CL_LOW   = 3'd4;
  localparam logic [2:0] CL_HIGH  = 3'd6;
  localparam int         CL_MAX   = 6;

endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
  import burst_seq_pkg::*;
#(
  parameter int MR_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MR_W-1:0] data,
  output mode_t           mode,
  output logic            err
);

  logic [2:0] bl_code;
  logic [2:0] cl_code;
  logic       spare_zero;
  logic       legal;
  mode_t      mode_q;
  logic       err_q;

  assign bl_code    = data[2:0];
  assign cl_code    = data[6:4];
  assign spare_zero = (data[MR_W-1:7] == '0);
  assign legal      = ((bl_code == BLC_TWO) || (bl_code == BLC_FOUR)) &&
                      (cl_code >= CL_LOW) && (cl_code <= CL_HIGH) && spare_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '{four: 1'b1, ilv: 1'b0, cl: CL_LOW};
      err_q  <= 1'b0;
    end else if (load) begin
      if (legal) begin
        mode_q <= '{four: (bl_code == BLC_FOUR), ilv: data[3], cl: cl_code};
        err_q  <= 1'b0;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  assign mode = mode_q;
  assign err  = err_q;

  AST_KEEP_ON_REJECT: assert property (@(posedge clk) disable iff (rst)
    (load && !legal) |=> $stable(mode_q)); // R3

  AST_CL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mode_q.cl >= CL_LOW) && (mode_q.cl <= CL_HIGH)); // R2

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [1:0]       beat,
  input  logic             four,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [1:0] low_seq;
  logic [1:0] low_ilv;
  logic [1:0] low_sel;

  always_comb begin
    low_seq = start[1:0] + beat;
    low_ilv = start[1:0] ^ beat;
    if (four) begin
      low_sel = ilv ? low_ilv : low_seq;
    end else begin
      low_sel = {start[1], start[0] ^ beat[0]};
    end
    col = {start[COL_W-1:2], low_sel};
  end

endmodule

// File: rtl/bseq_burst_ctl.sv
module bseq_burst_ctl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_lal,
  input  logic [COL_W-1:0] col_in,
  input  mode_t            mode,
  output logic [COL_W-1:0] start,
  output logic [1:0]       beat,
  output mode_t            acc_mode,
  output logic             rd_en,
  output logic             wr_en,
  output logic             done
);

  localparam int CNT_W = $clog2(CL_MAX + 1);

  phase_e           ph_q;
  logic             is_rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       beat_q;
  logic [1:0]       last_beat;
  logic [CNT_W-1:0] target;
  logic [COL_W-1:0] start_q;
  mode_t            acc_q;
  logic             rd_en_q;
  logic             wr_en_q;
  logic             done_q;

  assign last_beat = acc_q.four ? 2'd3 : 2'd1;
  assign target    = is_rd_q ? CNT_W'(acc_q.cl) : CNT_W'(acc_q.cl - 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      is_rd_q <= 1'b0;
      cnt_q   <= '0;
      beat_q  <= '0;
      start_q <= '0;
      acc_q   <= '0;
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (cmd_rd || cmd_wr) begin
            is_rd_q <= cmd_rd;
            ph_q    <= PH_ARMED;
          end
        end
        PH_ARMED: begin
          if (cmd_lal) begin
            start_q <= col_in;
            acc_q   <= mode;
            cnt_q   <= CNT_W'(1);
            ph_q    <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == target) begin
            ph_q    <= PH_BURST;
            beat_q  <= '0;
            rd_en_q <= is_rd_q;
            wr_en_q <= !is_rd_q;
            done_q  <= 1'b0;
          end
        end
        PH_BURST: begin
          if (beat_q == last_beat) begin
            rd_en_q <= 1'b0;
            wr_en_q <= 1'b0;
            done_q  <= 1'b0;
            ph_q    <= PH_IDLE;
          end else begin
            beat_q <= beat_q + 1'b1;
            done_q <= ((beat_q + 2'd1) == last_beat);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign start    = start_q;
  assign beat     = beat_q;
  assign acc_mode = acc_q;
  assign rd_en    = rd_en_q;
  assign wr_en    = wr_en_q;
  assign done     = done_q;

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_q && wr_en_q)); // R5

  AST_DONE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (rd_en_q || wr_en_q)); // R6

  AST_DONE_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !(rd_en_q || wr_en_q)); // R6

  AST_FIRST_BEAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en_q || wr_en_q) |-> (beat_q == 2'd0)); // R6

  AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (((ph_q == PH_WAIT) || (ph_q == PH_BURST)) && (cmd_rd || cmd_wr || cmd_lal))
      |=> (ph_q != PH_ARMED)); // R11

  AST_LATCHED_CL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT) |-> ((acc_q.cl >= CL_LOW) && (acc_q.cl <= CL_HIGH))); // R2

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int MR_W  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mr_load,
  input  logic [MR_W-1:0]  mr_data,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_lal,
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] beat_col,
  output logic             rd_cap_en,
  output logic             wr_drv_en,
  output logic             burst_done,
  output logic             mr_err
);

  mode_t            cur_mode;
  mode_t            acc_mode;
  logic [COL_W-1:0] start;
  logic [1:0]       beat;

  bseq_mode_reg #(.MR_W(MR_W)) i_mode (
    .clk  (clk),
    .rst  (rst),
    .load (mr_load),
    .data (mr_data),
    .mode (cur_mode),
    .err  (mr_err)
  );

  bseq_burst_ctl #(.COL_W(COL_W)) i_ctl (
    .clk      (clk),
    .rst      (rst),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .cmd_lal  (cmd_lal),
    .col_in   (col_in),
    .mode     (cur_mode),
    .start    (start),
    .beat     (beat),
    .acc_mode (acc_mode),
    .rd_en    (rd_cap_en),
    .wr_en    (wr_drv_en),
    .done     (burst_done)
  );

  bseq_addr_gen #(.COL_W(COL_W)) i_addr (
    .start (start),
    .beat  (beat),
    .four  (acc_mode.four),
    .ilv   (acc_mode.ilv),
    .col   (beat_col)
  );

endmodule

// File: tb/test_burst_seq_top.sv
`timescale 1ns/1ps
module test_burst_seq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mr_load = 1'b0;
  logic [14:0] mr_data = '0;
  logic        cmd_rd = 1'b0;
  logic        cmd_wr = 1'b0;
  logic        cmd_lal = 1'b0;
  logic [7:0]  col_in = '0;
  logic [7:0]  beat_col;
  logic        rd_cap_en;
  logic        wr_drv_en;
  logic        burst_done;
  logic        mr_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_seq_top #(.COL_W(8), .MR_W(15)) i_burst_seq_top (
    .clk(clk), .rst(rst), .mr_load(mr_load), .mr_data(mr_data),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_lal(cmd_lal), .col_in(col_in),
    .beat_col(beat_col), .rd_cap_en(rd_cap_en), .wr_drv_en(wr_drv_en),
    .burst_done(burst_done), .mr_err(mr_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] mw(input logic [2:0] bl, input logic ilv,
                                     input logic [2:0] cl);
    return {8'd0, cl, ilv, bl};
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int b,
                                         input bit four, input bit ilv);
    logic [1:0] bb;
    logic [1:0] sum;
    bb  = 2'(b);
    sum = s[1:0] + bb;
    if (!four) return {s[7:1], s[0] ^ bb[0]};
    if (ilv)   return {s[7:2], s[1:0] ^ bb};
    return {s[7:2], sum};
  endfunction

  task automatic load_mode(input logic [14:0] v, input bit exp_err, input string req);
    @(negedge clk);
    mr_load = 1'b1;
    mr_data = v;
    @(negedge clk);
    mr_load = 1'b0;
    chk(req, "mr_err after load", 32'(mr_err), 32'(exp_err));
  endtask

  // One access; expected settings are passed in, timing is checked each cycle.
  task automatic run_access(input bit rd, input logic [7:0] col, input int cl,
                            input bit four, input bit ilv, input bit inject,
                            input bit mr_with_lal, input logic [14:0] mrv,
                            input string req);
    int d;
    int bl;
    d  = rd ? cl : cl - 1;
    bl = four ? 4 : 2;
    @(negedge clk);
    cmd_rd = rd;
    cmd_wr = !rd;
    @(negedge clk);
    cmd_rd  = 1'b0;
    cmd_wr  = 1'b0;
    cmd_lal = 1'b1;
    col_in  = col;
    if (mr_with_lal) begin
      mr_load = 1'b1;
      mr_data = mrv;
    end
    @(negedge clk);
    cmd_lal = 1'b0;
    mr_load = 1'b0;
    for (int j = 0; j <= d + bl + 1; j++) begin
      bit win;
      win = (j >= d) && (j < d + bl);
      chk(req, $sformatf("rd_cap_en j=%0d", j), 32'(rd_cap_en), 32'(rd && win));
      chk(req, $sformatf("wr_drv_en j=%0d", j), 32'(wr_drv_en), 32'(!rd && win));
      chk("R6", $sformatf("burst_done j=%0d", j), 32'(burst_done),
          32'(j == d + bl - 1));
      if (win)
        chk(req, $sformatf("beat_col beat=%0d", j - d), 32'(beat_col),
            32'(exp_col(col, j - d, four, ilv)));
      if (inject) begin
        cmd_wr  = (j == 1);
        cmd_lal = (j == 2) || (j == d + 1);
      end
      @(negedge clk);
    end
    cmd_wr  = 1'b0;
    cmd_lal = 1'b0;
  endtask

  task automatic lone_latch(input string req);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    cmd_lal = 1'b1;
    col_in  = 8'h11;
    @(negedge clk);
    cmd_lal = 1'b0;
    for (int j = 0; j < 10; j++) begin
      if (rd_cap_en || wr_drv_en || burst_done) seen = 1'b1;
      @(negedge clk);
    end
    chk(req, "enable after lone latch", 32'(seen), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "rd_cap_en at reset", 32'(rd_cap_en), 32'd0);
    chk("R1", "wr_drv_en at reset", 32'(wr_drv_en), 32'd0);
    chk("R1", "burst_done at reset", 32'(burst_done), 32'd0);
    chk("R1", "mr_err at reset", 32'(mr_err), 32'd0);
    run_access(1'b1, 8'h5E, 4, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R1");
  endtask

  task automatic t_sequential;
    run_access(1'b1, 8'hC7, 4, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R7");
    run_access(1'b0, 8'h3D, 4, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R5");
    load_mode(mw(3'd1, 1'b0, 3'd6), 1'b0, "R2");
    run_access(1'b1, 8'hA3, 6, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R4");
    run_access(1'b0, 8'hF0, 6, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R5");
  endtask

  task automatic t_interleave;
    load_mode(mw(3'd2, 1'b1, 3'd5), 1'b0, "R2");
    run_access(1'b1, 8'h71, 5, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R8");
    run_access(1'b0, 8'h32, 5, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R9");
    load_mode(mw(3'd1, 1'b1, 3'd4), 1'b0, "R2");
    run_access(1'b1, 8'h9B, 4, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R8");
    load_mode(mw(3'd2, 1'b1, 3'd5), 1'b0, "R2");
  endtask

  task automatic t_reject;
    load_mode(mw(3'd2, 1'b0, 3'd7), 1'b1, "R3");
    load_mode(mw(3'd3, 1'b0, 3'd4), 1'b1, "R3");
    load_mode(mw(3'd1, 1'b0, 3'd4) | 15'h0080, 1'b1, "R3");
    load_mode(mw(3'd1, 1'b0, 3'd4) | 15'h4000, 1'b1, "R3");
    load_mode(mw(3'd0, 1'b0, 3'd6), 1'b1, "R3");
    run_access(1'b1, 8'h46, 5, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R3");
    load_mode(mw(3'd2, 1'b0, 3'd4), 1'b0, "R3");
  endtask

  task automatic t_ignore;
    lone_latch("R10");
    run_access(1'b1, 8'h2A, 4, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R11");
    lone_latch("R11");
  endtask

  task automatic t_collide;
    run_access(1'b1, 8'h65, 4, 1'b1, 1'b0, 1'b0, 1'b1, mw(3'd1, 1'b0, 3'd6), "R12");
    chk("R12", "mr_err after joint load", 32'(mr_err), 32'd0);
    run_access(1'b1, 8'h65, 6, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_interleave();
    t_reject();
    t_ignore();
    t_collide();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule